// File: doc/BRIEF.md
# Header-Framed SPI Master Transmitter

This block is an SPI master that pushes fixed-length packets to one slave. A packet is a constant sync word (0xAA) followed by eight payload words of eight bits each, 72 bits in all. Chip select stays low for the whole packet. The serial clock idles high, and MOSI changes only on rising edges, so a slave that samples on the falling edge sees stable data. The serial clock runs at the system clock divided by 2·DIV.

The user side is a one-cycle start strobe with a 64-bit payload, plus busy and done flags. The payload is captured when the start is accepted. After that, the block ignores its inputs until the packet is over. A one-cycle done pulse follows the release of chip select. A new start may be given in the same cycle as that pulse.

Top module: `hdr_spi_tx`

## Requirements
- R1: Out of reset and while idle: sclk_o=1, cs_n_o=1, mosi_o=0, busy_o=0, done_o=0.
- R2: A start_i seen high at a clock edge while busy_o=0 is accepted. From the next cycle, cs_n_o=0, busy_o=1 and sclk_o=1. The first falling edge of sclk_o comes exactly DIV cycles after cs_n_o falls.
- R3: The first eight bits of every packet are the sync word 0xAA, most significant bit first.
- R4: The payload follows as eight words, each MSB first. Word 0 is payload_i[7:0] and word 7 is payload_i[63:56]. A packet has exactly 72 falling edges of sclk_o.
- R5: Every low and high half period of sclk_o lasts exactly DIV system cycles.
- R6: While cs_n_o=0, mosi_o changes only in a cycle where sclk_o has just risen, or when cs_n_o has just fallen. It never changes across a falling edge.
- R7: cs_n_o stays low for the whole packet. After the last rising edge of sclk_o, the clock stays high for 2·DIV cycles before cs_n_o returns high.
- R8: start_i while busy_o=1, and any change of payload_i after acceptance, have no effect on the packet being sent.
- R9: done_o is high for exactly one cycle: the cycle after the first cycle in which cs_n_o is high again. busy_o drops in that same cycle, and a start in that cycle is accepted.
- R10: mosi_o is 0 whenever cs_n_o is 1.
- R11: A synchronous low on rst_n aborts a packet. At the next edge the outputs return to the idle values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for one packet |
| payload_i | input | 64 | Payload; word 0 in bits 7:0 |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle end-of-packet pulse |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |

## Verification
Each result has a fixed due cycle, counted from the edge that accepts the start:
- chip select, busy and the first bit appear one cycle after that edge;
- the first falling edge comes DIV cycles later, and every half period lasts DIV cycles;
- chip select rises 2·DIV cycles after the last rising edge;
- done follows one cycle after that, so a packet takes 146·DIV+2 cycles.

A behavioural model expands each accepted start into a queue holding one expected output vector per cycle. The bench pops one entry per rising edge and compares the whole vector at the following falling edge. A small slave model shifts MOSI in on each observed falling edge of sclk_o and checks the sync word, the payload and the bit count when chip select is released.

// File: rtl/hst_pkg.sv
package hst_pkg;
    // Control states of the packet sequencer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } hst_state_e;

    // Constant word placed in front of every payload
    localparam logic [7:0] HST_SYNC_WORD = 8'hAA;
endpackage

// File: rtl/hst_tick_gen.sv
// Half-period timer.
// While run_i is high, tick_o fires once every DIV cycles, on the last
// cycle of each half period. The count clears whenever run_i is low, so
// every phase entered from idle starts at a full DIV length.
// Assumes DIV >= 1.
module hst_tick_gen #(
    parameter int DIV   = 2,
    parameter int CNT_W = $clog2(DIV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    // Count system cycles inside the current half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hst_shifter.sv
// Packet shift register.
// On load_i it captures the sync word followed by the payload words, with
// word 0 (lowest bits of payload_i) placed directly after the sync word.
// Each shift_i moves the next bit to the MSB, which drives the serial line.
module hst_shifter #(
    parameter int               WORD_W    = 8,
    parameter int               PAY_WORDS = 8,
    parameter logic [WORD_W-1:0] SYNC_WORD = 8'hAA,
    parameter int               PAY_W     = WORD_W * PAY_WORDS,
    parameter int               PKT_W     = WORD_W * (PAY_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [PAY_W-1:0] payload_i,
    output logic             msb_o
);
    logic [PKT_W-1:0] pkt_w;
    logic [PKT_W-1:0] sr_q;

    assign pkt_w[PKT_W-1 -: WORD_W] = SYNC_WORD;

    // Reorder payload words so that word 0 leaves first
    for (genvar g = 0; g < PAY_WORDS; g++) begin : g_word
        assign pkt_w[PAY_W-1-g*WORD_W -: WORD_W] = payload_i[g*WORD_W +: WORD_W];
    end

    // Hold and advance the packet bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= pkt_w;
        end else if (shift_i) begin
            sr_q <= {sr_q[PKT_W-2:0], 1'b0};
        end
    end

    assign msb_o = sr_q[PKT_W-1];
endmodule

// File: rtl/hst_ctrl.sv
// Packet sequencer.
// A packet runs through these phases:
//   - one setup half period, with select low and the clock high;
//   - for each bit, a low half period followed by a high half period;
//   - one hold half period;
//   - one gap cycle, with select already high.
// After the gap comes the done cycle. The serial clock and select are
// registered from the next state, so they change exactly on phase
// boundaries. A shift is requested at each rising edge except after the
// last bit. Assumes tick_i comes from a timer gated by run_o.
module hst_ctrl
    import hst_pkg::*;
#(
    parameter int PKT_W = 72,
    parameter int BIT_W = $clog2(PKT_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic run_o,
    output logic load_o,
    output logic shift_o,
    output logic busy_o,
    output logic done_o,
    output logic sclk_o,
    output logic cs_n_o
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PKT_W - 1);

    hst_state_e       state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic             last_bit;
    logic             sclk_q, cs_n_q, done_q;

    assign last_bit = (bit_q == LAST_BIT);
    assign load_o   = (state_q == ST_IDLE) && start_i;
    assign shift_o  = (state_q == ST_LOW) && tick_i && !last_bit;
    assign run_o    = (state_q == ST_SETUP) || (state_q == ST_LOW) ||
                      (state_q == ST_HIGH)  || (state_q == ST_HOLD);
    assign busy_o   = (state_q != ST_IDLE);

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: if (tick_i)  state_d = ST_LOW;
            ST_LOW:   if (tick_i)  state_d = ST_HIGH;
            ST_HIGH:  if (tick_i)  state_d = last_bit ? ST_HOLD : ST_LOW;
            ST_HOLD:  if (tick_i)  state_d = ST_GAP;
            ST_GAP:                state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                bit_q <= '0;
            end else if ((state_q == ST_HIGH) && tick_i && !last_bit) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Registered serial clock, select and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            sclk_q <= (state_d != ST_LOW);
            cs_n_q <= (state_d == ST_IDLE) || (state_d == ST_GAP);
            done_q <= (state_q == ST_GAP);
        end
    end

    assign sclk_o = sclk_q;
    assign cs_n_o = cs_n_q;
    assign done_o = done_q;
endmodule

// File: rtl/hdr_spi_tx.sv
// Header-framed SPI master transmitter (top).
// Sends one sync word and PAY_WORDS payload words per start, MSB first.
// The clock idles high and data changes on rising edges. The serial clock
// is clk / (2*DIV). Assumes DIV >= 1 and start_i synchronous to clk.
module hdr_spi_tx
    import hst_pkg::*;
#(
    parameter int                DIV       = 2,
    parameter int                WORD_W    = 8,
    parameter int                PAY_WORDS = 8,
    parameter logic [WORD_W-1:0] SYNC_WORD = HST_SYNC_WORD
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [WORD_W*PAY_WORDS-1:0]   payload_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          sclk_o,
    output logic                          cs_n_o,
    output logic                          mosi_o
);
    localparam int PAY_W = WORD_W * PAY_WORDS;
    localparam int PKT_W = WORD_W * (PAY_WORDS + 1);
    localparam int CNT_W = $clog2(DIV + 1);
    localparam int BIT_W = $clog2(PKT_W);

    logic run_w, tick_w, load_w, shift_w, msb_w;

    hst_tick_gen #(
        .DIV   (DIV),
        .CNT_W (CNT_W)
    ) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .tick_o (tick_w)
    );

    hst_ctrl #(
        .PKT_W (PKT_W),
        .BIT_W (BIT_W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .tick_i  (tick_w),
        .run_o   (run_w),
        .load_o  (load_w),
        .shift_o (shift_w),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .sclk_o  (sclk_o),
        .cs_n_o  (cs_n_o)
    );

    hst_shifter #(
        .WORD_W    (WORD_W),
        .PAY_WORDS (PAY_WORDS),
        .SYNC_WORD (SYNC_WORD),
        .PAY_W     (PAY_W),
        .PKT_W     (PKT_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .shift_i   (shift_w),
        .payload_i (payload_i),
        .msb_o     (msb_w)
    );

    // Data line is parked low whenever the slave is deselected
    assign mosi_o = !cs_n_o && msb_w;
endmodule

// File: rtl/hdr_spi_tx_chk.sv
// Protocol checker for hdr_spi_tx, attached by bind.
module hdr_spi_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic sclk_o,
    input logic cs_n_o,
    input logic mosi_o
);
    // R1
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !cs_n_o && sclk_o));

    // R6
    mosi_stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $fell(sclk_o)) |-> $stable(mosi_o));

    // R7
    cs_release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n_o) && $past(rst_n)) |-> (sclk_o && $past(sclk_o)));

    // R9
    done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $past(cs_n_o) && !busy_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    mosi_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !mosi_o);

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cs_n_o && sclk_o && !busy_o && !done_o));
endmodule

bind hdr_spi_tx hdr_spi_tx_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o),
    .mosi_o  (mosi_o)
);

// File: tb/hdr_spi_tx_tb_top.sv
module hdr_spi_tx_tb_top;
    localparam int TB_DIV = 2;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic mosi;
        logic busy;
        logic done;
    } exp_t;

    localparam exp_t IDLE_E = '{sclk: 1'b1, cs_n: 1'b1, mosi: 1'b0, busy: 1'b0, done: 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] payload_i = '0;
    logic        busy_o, done_o, sclk_o, cs_n_o, mosi_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    exp_t cur = IDLE_E;
    exp_t q[$];
    logic [63:0] acc_pay = '0;

    always #10 clk = ~clk;

    hdr_spi_tx #(.DIV(TB_DIV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .payload_i (payload_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .sclk_o    (sclk_o),
        .cs_n_o    (cs_n_o),
        .mosi_o    (mosi_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic s, input logic c, input logic m,
                                input logic b, input logic d);
        exp_t e;
        e.sclk = s; e.cs_n = c; e.mosi = m; e.busy = b; e.done = d;
        return e;
    endfunction

    // Expand one accepted start into per-cycle expectations
    function automatic void plan_packet(input logic [63:0] p);
        logic [71:0] bits;
        logic nb;
        bits[71:64] = 8'hAA;
        for (int i = 0; i < 8; i++) bits[63-8*i -: 8] = p[8*i +: 8];
        for (int d = 0; d < TB_DIV; d++) q.push_back(mk(1, 0, bits[71], 1, 0));
        for (int k = 0; k < 72; k++) begin
            for (int d = 0; d < TB_DIV; d++) q.push_back(mk(0, 0, bits[71-k], 1, 0));
            nb = (k == 71) ? bits[0] : bits[70-k];
            for (int d = 0; d < TB_DIV; d++) q.push_back(mk(1, 0, nb, 1, 0));
        end
        for (int d = 0; d < TB_DIV; d++) q.push_back(mk(1, 0, bits[0], 1, 0));
        q.push_back(mk(1, 1, 0, 1, 0));
        q.push_back(mk(1, 1, 0, 0, 1));
    endfunction

    // Reference model: advance one cycle at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = IDLE_E;
        end else if (start_i && !cur.busy) begin
            acc_pay = payload_i;
            plan_packet(payload_i);
            cur = q.pop_front();
        end else if (q.size() > 0) begin
            cur = q.pop_front();
        end else begin
            cur = IDLE_E;
        end
    end

    // Cycle compare and slave capture, away from the active edge
    logic        p_sclk = 1'b1, p_cs_n = 1'b1, p_mosi = 1'b0;
    bit          cap_on = 1'b0;
    int          cap_cnt = 0;
    int          since_cs = 0;
    bit          first_fall = 1'b0;
    logic [71:0] cap_bits = '0;

    always @(negedge clk) begin
        exp_t act;
        string req;
        act = mk(sclk_o, cs_n_o, mosi_o, busy_o, done_o);
        if (act !== cur) begin
            if (act.sclk !== cur.sclk)      req = "R5";
            else if (act.cs_n !== cur.cs_n) req = "R7";
            else if (act.mosi !== cur.mosi) req = "R4";
            else if (act.busy !== cur.busy) req = "R8";
            else                            req = "R9";
        end else begin
            req = "R5";
        end
        check(act === cur, req, "cycle compare {sclk,cs_n,mosi,busy,done}",
              64'(act), 64'(cur));

        if (!rst_n) begin
            cap_on = 1'b0;
        end else begin
            if (p_cs_n && !cs_n_o) begin
                cap_on = 1'b1; cap_cnt = 0; since_cs = 0; first_fall = 1'b1;
            end else if (cap_on) begin
                since_cs++;
            end
            // R6: data moves only right after a rising edge
            if (cap_on && !p_cs_n && !cs_n_o && (mosi_o !== p_mosi))
                check(!p_sclk && sclk_o, "R6", "mosi change without rising sclk",
                      64'({p_sclk, sclk_o}), 64'(2'b01));
            if (cap_on && !cs_n_o && p_sclk && !sclk_o) begin
                if (first_fall) begin
                    check(since_cs == TB_DIV, "R2", "cycles from select to first fall",
                          64'(since_cs), 64'(TB_DIV));
                    first_fall = 1'b0;
                end
                cap_bits = {cap_bits[70:0], mosi_o};
                cap_cnt++;
            end
            if (cap_on && !p_cs_n && cs_n_o) begin
                logic [63:0] want;
                for (int i = 0; i < 8; i++) want[63-8*i -: 8] = acc_pay[8*i +: 8];
                check(cap_cnt == 72, "R4", "falling edges per packet", 64'(cap_cnt), 64'd72);
                check(cap_bits[71:64] == 8'hAA, "R3", "sync word", 64'(cap_bits[71:64]), 64'hAA);
                check(cap_bits[63:0] == want, "R4", "payload order", cap_bits[63:0], want);
                check(!mosi_o, "R10", "mosi while deselected", 64'(mosi_o), 64'd0);
                cap_on = 1'b0;
            end
        end
        p_sclk = sclk_o; p_cs_n = cs_n_o; p_mosi = mosi_o;
    end

    task automatic send(input logic [63:0] p);
        @(negedge clk);
        start_i = 1'b1; payload_i = p;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle values out of reset
        check({sclk_o, cs_n_o, mosi_o, busy_o, done_o} === 5'b11000, "R1",
              "reset outputs", 64'({sclk_o, cs_n_o, mosi_o, busy_o, done_o}), 64'(5'b11000));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        send(64'h0123_4567_89AB_CDEF);
        wait_done();
        // R9: back-to-back start in the done cycle
        check(!busy_o, "R9", "busy in done cycle", 64'(busy_o), 64'd0);
        start_i = 1'b1; payload_i = 64'hFFFF_0000_A5A5_C33C;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !cs_n_o, "R9", "start accepted in done cycle",
              64'({busy_o, cs_n_o}), 64'(2'b10));
        // R8: stray start and payload changes during a packet
        repeat (20) @(negedge clk);
        start_i = 1'b1; payload_i = 64'hDEAD_BEEF_0BAD_F00D;
        @(negedge clk);
        start_i = 1'b0; payload_i = 64'h1111_2222_3333_4444;
        wait_done();
        repeat (5) @(negedge clk);

        send(64'h0);
        wait_done();
        send(64'hFFFF_FFFF_FFFF_FFFF);
        wait_done();
        send(64'h8000_0000_0000_0001);
        wait_done();
        repeat (3) @(negedge clk);

        // R11: abort mid-packet
        send(64'h5A5A_5A5A_5A5A_5A5A);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({sclk_o, cs_n_o, mosi_o, busy_o, done_o} === 5'b11000, "R11",
              "outputs after abort", 64'({sclk_o, cs_n_o, mosi_o, busy_o, done_o}), 64'(5'b11000));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send(64'hC001_D00D_1234_8765);
        wait_done();
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual=hang expected=done");
            summary();
        end
    end
endmodule